// File: doc/BRIEF.md
# Interrupt and Trap Status Controller

This block owns a processor's status register together with the exception program counter, the exception vector, the cause register, a cycle-style count/compare timer and a host mailbox register. Every cycle it decides whether the core must leave its current flow, either for a synchronous exception that the pipeline reports or for an enabled pending interrupt. On entry it rewrites the mode bits of status, saves the PC, records the cause and redirects fetch to the vector.

Software reaches the state through a single-cycle CSR port with a combinational read. Three interrupt sources exist: inter-processor (IPI), host and timer. Each has a hardware set and a hardware clear input, and CSR writes to the compare, clear-IPI and host mailbox registers also drive them. A one-cycle pulse on the redirect strobe also tells the memory side to drop any load reservation.

Top module: `trap_status_ctrl`

## Requirements
- R1: An interrupt is taken only when its pending bit, its mask bit and the global enable (status bit 0) are all set. Pending bits are status[23:16], mask bits are status[15:8], and a source of index k uses bit k of each field.
- R2: When more than one enabled interrupt is pending, the one with the lowest index is taken. IPI has index 5, host index 6 and timer index 7.
- R3: An interrupt cause is the source index added to a top bit. The top bit is bit 63 when the 64-bit supervisor bit (status bit 5) is set, and bit 31 when it is clear.
- R4: On trap entry, status bit 2 (supervisor) becomes 1 and bit 0 (global enable) becomes 0. Bit 3 takes the old supervisor bit and bit 1 takes the old global enable. Mask, pending and the 64-bit bits are kept.
- R5: A trap decided in one cycle loads cause, loads epc with the trapping PC (trap_pc for an exception, cur_pc for an interrupt) and loads redirect_pc with evec at the next clock edge. trap_taken and resv_clear are high for that one following cycle.
- R6: A CSR write to status (address 0) replaces the mode and mask fields but leaves the pending field unchanged. Bits 31:24 and 7:6 read as zero, and so do bits 5:4 when 64-bit support is off.
- R7: A write to compare (address 4) clears timer pending. A retire pulse that moves count from below compare to at or above it sets timer pending.
- R8: A write to clear-IPI (address 6) sets IPI pending to bit 0 of the written value. A write to the host mailbox (address 7) stores the value, sets host pending if the value is nonzero and clears it if the value is zero.
- R9: After reset, status holds only the supervisor bit (0x4), redirect_pc is 0x2000, trap_taken and resv_clear are low, and count, compare, epc, evec, cause and the mailbox are zero.
- R10: count (address 3, 32 bits) rises by one on each retire pulse and wraps from 0xFFFFFFFF to 0. A CSR write to count in the same cycle takes priority over the increment.
- R11: When a trap request and a takeable interrupt arrive in the same cycle, the exception is taken with its own cause and PC, and the interrupt stays pending.
- R12: When a hardware set of a pending bit meets a CSR write that would clear the same bit in the same cycle, the bit ends up set.
- R13: The other CSR addresses are epc 1, evec 2 and cause 5. Clear-IPI reads as zero. A trap entry overrides a CSR write to status or epc in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | CSR write enable |
| csr_addr | input | 3 | CSR select |
| csr_wdata | input | 64 | CSR write data |
| csr_rdata | output | 64 | CSR read data, combinational from csr_addr |
| irq_set | input | 3 | Hardware set of pending: bit 0 IPI, bit 1 host, bit 2 timer |
| irq_clr | input | 3 | Hardware clear of pending, same bit order |
| retire | input | 1 | Retire pulse that advances count |
| cur_pc | input | 64 | PC saved when an interrupt is taken |
| trap_req | input | 1 | Synchronous exception request |
| trap_pc | input | 64 | PC of the faulting instruction |
| trap_cause | input | 64 | Cause code of the exception |
| trap_taken | output | 1 | One-cycle strobe after a trap entry |
| redirect_pc | output | 64 | Fetch target; evec after a trap, 0x2000 from reset |
| cause_o | output | 64 | Current cause register |
| resv_clear | output | 1 | Drop-reservation pulse, high together with trap_taken |

## Verification
CSR writes, hardware set and clear pulses, and retire pulses all take effect at the first clock edge after they are driven, so the bench reads status, count or mailbox at the next falling edge. An interrupt made takeable by a write or a set needs a second edge to enter the trap, and an exception request needs only one. In both cases trap_taken, redirect_pc and cause_o are due one cycle after the deciding cycle. The driver puts each expected entry into a queue before it applies the stimulus. A monitor that samples on every falling edge pops one entry per strobe, and it reports a strobe with an empty queue, or an entry left in the queue at the end, as a failure.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [2:0] {
    CSR_STATUS   = 3'd0,
    CSR_EPC      = 3'd1,
    CSR_EVEC     = 3'd2,
    CSR_COUNT    = 3'd3,
    CSR_COMPARE  = 3'd4,
    CSR_CAUSE    = 3'd5,
    CSR_IPI_CLR  = 3'd6,
    CSR_MAILBOX  = 3'd7
  } csr_sel_e;

  // status layout
  localparam int ST_GIE     = 0;
  localparam int ST_PGIE    = 1;
  localparam int ST_SUP     = 2;
  localparam int ST_PSUP    = 3;
  localparam int ST_U64     = 4;
  localparam int ST_S64     = 5;
  localparam int ST_MODE_W  = 8;
  localparam int NIRQ       = 8;
  localparam int ST_MASK_LO = ST_MODE_W;
  localparam int ST_PEND_LO = ST_MODE_W + NIRQ;
  localparam int ST_W       = 32;

  // interrupt sources
  localparam int NSRC      = 3;
  localparam int SRC_IPI   = 0;
  localparam int SRC_HOST  = 1;
  localparam int SRC_TIMER = 2;
  localparam int IRQ_BASE  = 5;
endpackage

// File: rtl/tsc_status.sv
module tsc_status
  import tsc_pkg::*;
#(
  parameter bit EN64 = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [ST_W-1:0] wr_data,
  input  logic            trap_enter,
  input  logic [NIRQ-1:0] hw_set,
  input  logic [NIRQ-1:0] hw_clr,
  output logic [ST_W-1:0] status_o
);
  localparam logic [ST_MODE_W-1:0] MODE_WMASK = EN64 ? 8'h3F : 8'h0F;
  localparam logic [ST_MODE_W-1:0] MODE_RST   = ST_MODE_W'(1) << ST_SUP;
  localparam int PAD_W = ST_W - ST_MODE_W - 2 * NIRQ;

  logic [ST_MODE_W-1:0] mode_q, mode_n;
  logic [NIRQ-1:0]      mask_q, mask_n;
  logic [NIRQ-1:0]      pend_q, pend_n;

  always_comb begin
    mode_n = mode_q;
    mask_n = mask_q;
    if (trap_enter) begin
      mode_n[ST_SUP]  = 1'b1;
      mode_n[ST_GIE]  = 1'b0;
      mode_n[ST_PSUP] = mode_q[ST_SUP];
      mode_n[ST_PGIE] = mode_q[ST_GIE];
    end else if (wr_en) begin
      mode_n = wr_data[ST_MODE_W-1:0] & MODE_WMASK;
      mask_n = wr_data[ST_MASK_LO +: NIRQ];
    end
    pend_n = (pend_q & ~hw_clr) | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      mode_q <= mode_n;
      mask_q <= mask_n;
      pend_q <= pend_n;
    end
  end

  assign status_o = {{PAD_W{1'b0}}, pend_q, mask_q, mode_q};

  p_pend_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hw_set == '0 && hw_clr == '0) |=> $stable(pend_q));

  p_entry_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_enter |=> (status_o[ST_SUP] && !status_o[ST_GIE]
                    && status_o[ST_PGIE] == $past(status_o[ST_GIE])
                    && status_o[ST_PSUP] == $past(status_o[ST_SUP])));
endmodule

// File: rtl/tsc_timer.sv
module tsc_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] compare_o,
  output logic             cross_o
);
  logic [CNT_W-1:0] count_q, count_n, cmp_q, cmp_n;
  logic [CNT_W:0]   count_inc;

  always_comb begin
    count_inc = {1'b0, count_q} + (CNT_W + 1)'(1);
    count_n   = count_q;
    if (cnt_we)      count_n = wdata;
    else if (retire) count_n = count_inc[CNT_W-1:0];
    cmp_n = cmp_we ? wdata : cmp_q;
    cross_o = retire && !cnt_we && (count_q < cmp_q)
              && (count_inc >= {1'b0, cmp_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      cmp_q   <= '0;
    end else begin
      count_q <= count_n;
      cmp_q   <= cmp_n;
    end
  end

  assign count_o   = count_q;
  assign compare_o = cmp_q;

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !cnt_we) |=> count_o == $past(count_o) + CNT_W'(1));
endmodule

// File: rtl/tsc_irq_pick.sv
module tsc_irq_pick #(
  parameter int XLEN  = 64,
  parameter int NIRQ  = 8,
  parameter int IDX_W = $clog2(NIRQ)
) (
  input  logic [NIRQ-1:0] pend,
  input  logic [NIRQ-1:0] mask,
  input  logic            gie,
  input  logic            s64,
  output logic            take,
  output logic [XLEN-1:0] cause
);
  localparam logic [XLEN-1:0] TOP_WIDE   = XLEN'(1) << (XLEN - 1);
  localparam logic [XLEN-1:0] TOP_NARROW = XLEN'(1) << 31;

  logic [NIRQ-1:0]  act;
  logic [IDX_W-1:0] idx;

  always_comb begin
    act  = pend & mask;
    take = gie && (|act);
    idx  = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (act[i]) idx = IDX_W'(i);
    end
    cause = (s64 ? TOP_WIDE : TOP_NARROW) + XLEN'(idx);
  end
endmodule

// File: rtl/trap_status_ctrl.sv
module trap_status_ctrl
  import tsc_pkg::*;
#(
  parameter int              XLEN     = 64,
  parameter int              CNT_W    = 32,
  parameter bit              EN64     = 1'b1,
  parameter logic [XLEN-1:0] START_PC = 64'h2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic [2:0]      csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic [2:0]      irq_set,
  input  logic [2:0]      irq_clr,
  input  logic            retire,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            trap_req,
  input  logic [XLEN-1:0] trap_pc,
  input  logic [XLEN-1:0] trap_cause,
  output logic            trap_taken,
  output logic [XLEN-1:0] redirect_pc,
  output logic [XLEN-1:0] cause_o,
  output logic            resv_clear
);
  csr_sel_e        sel;
  logic            we_status, we_epc, we_evec, we_count, we_cmp, we_ipi, we_mbox;
  logic [ST_W-1:0] status;
  logic [NIRQ-1:0] hw_set, hw_clr;
  logic [NSRC-1:0] src_set, src_clr;
  logic            timer_cross, irq_take, enter;
  logic [XLEN-1:0] irq_cause, ent_cause, ent_pc;
  logic [CNT_W-1:0] count, compare;

  logic [XLEN-1:0] epc_q, epc_n, evec_q, evec_n, cause_q, cause_n;
  logic [XLEN-1:0] mbox_q, mbox_n, redir_q, redir_n;
  logic            taken_q;

  // CSR write decode
  always_comb begin
    sel       = csr_sel_e'(csr_addr);
    we_status = csr_we && sel == CSR_STATUS;
    we_epc    = csr_we && sel == CSR_EPC;
    we_evec   = csr_we && sel == CSR_EVEC;
    we_count  = csr_we && sel == CSR_COUNT;
    we_cmp    = csr_we && sel == CSR_COMPARE;
    we_ipi    = csr_we && sel == CSR_IPI_CLR;
    we_mbox   = csr_we && sel == CSR_MAILBOX;
  end

  // per-source set/clear, hardware and CSR side effects merged
  always_comb begin
    src_set = irq_set;
    src_clr = irq_clr;
    src_set[SRC_IPI]   = irq_set[SRC_IPI]   | (we_ipi && csr_wdata[0]);
    src_clr[SRC_IPI]   = irq_clr[SRC_IPI]   | (we_ipi && !csr_wdata[0]);
    src_set[SRC_HOST]  = irq_set[SRC_HOST]  | (we_mbox && csr_wdata != '0);
    src_clr[SRC_HOST]  = irq_clr[SRC_HOST]  | (we_mbox && csr_wdata == '0);
    src_set[SRC_TIMER] = irq_set[SRC_TIMER] | timer_cross;
    src_clr[SRC_TIMER] = irq_clr[SRC_TIMER] | we_cmp;
  end

  for (genvar b = 0; b < NIRQ; b++) begin : g_irq_map
    if (b >= IRQ_BASE && b < IRQ_BASE + NSRC) begin : g_src
      assign hw_set[b] = src_set[b - IRQ_BASE];
      assign hw_clr[b] = src_clr[b - IRQ_BASE];
    end else begin : g_none
      assign hw_set[b] = 1'b0;
      assign hw_clr[b] = 1'b0;
    end
  end

  tsc_status #(.EN64(EN64)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (we_status),
    .wr_data    (csr_wdata[ST_W-1:0]),
    .trap_enter (enter),
    .hw_set     (hw_set),
    .hw_clr     (hw_clr),
    .status_o   (status)
  );

  tsc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .retire    (retire),
    .cnt_we    (we_count),
    .cmp_we    (we_cmp),
    .wdata     (csr_wdata[CNT_W-1:0]),
    .count_o   (count),
    .compare_o (compare),
    .cross_o   (timer_cross)
  );

  tsc_irq_pick #(.XLEN(XLEN), .NIRQ(NIRQ)) u_pick (
    .pend  (status[ST_PEND_LO +: NIRQ]),
    .mask  (status[ST_MASK_LO +: NIRQ]),
    .gie   (status[ST_GIE]),
    .s64   (status[ST_S64]),
    .take  (irq_take),
    .cause (irq_cause)
  );

  // trap arbitration: the synchronous exception wins
  always_comb begin
    enter     = trap_req || irq_take;
    ent_cause = trap_req ? trap_cause : irq_cause;
    ent_pc    = trap_req ? trap_pc : cur_pc;
    epc_n     = enter ? ent_pc : (we_epc ? csr_wdata : epc_q);
    evec_n    = we_evec ? csr_wdata : evec_q;
    cause_n   = enter ? ent_cause : cause_q;
    mbox_n    = we_mbox ? csr_wdata : mbox_q;
    redir_n   = enter ? evec_q : redir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      evec_q  <= '0;
      cause_q <= '0;
      mbox_q  <= '0;
      redir_q <= START_PC;
      taken_q <= 1'b0;
    end else begin
      epc_q   <= epc_n;
      evec_q  <= evec_n;
      cause_q <= cause_n;
      mbox_q  <= mbox_n;
      redir_q <= redir_n;
      taken_q <= enter;
    end
  end

  always_comb begin
    unique case (sel)
      CSR_STATUS:  csr_rdata = XLEN'(status);
      CSR_EPC:     csr_rdata = epc_q;
      CSR_EVEC:    csr_rdata = evec_q;
      CSR_COUNT:   csr_rdata = XLEN'(count);
      CSR_COMPARE: csr_rdata = XLEN'(compare);
      CSR_CAUSE:   csr_rdata = cause_q;
      CSR_IPI_CLR: csr_rdata = '0;
      CSR_MAILBOX: csr_rdata = mbox_q;
      default:     csr_rdata = '0;
    endcase
  end

  assign trap_taken  = taken_q;
  assign resv_clear  = taken_q;
  assign redirect_pc = redir_q;
  assign cause_o     = cause_q;

  p_taken_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> (status[ST_SUP] && !status[ST_GIE]));

  p_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |-> redirect_pc == $past(evec_q));

  p_sync_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_taken && $past(trap_req)) |-> cause_o == $past(trap_cause));

  p_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[ST_GIE] && !trap_req) |=> !trap_taken);
endmodule

// File: tb/test_trap_status_ctrl.sv
module test_trap_status_ctrl;
  typedef struct {
    logic [63:0] pc;
    logic [63:0] cause;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_we;
  logic [2:0]  csr_addr;
  logic [63:0] csr_wdata, csr_rdata;
  logic [2:0]  irq_set, irq_clr;
  logic        retire;
  logic [63:0] cur_pc, trap_pc, trap_cause;
  logic        trap_req;
  logic        trap_taken, resv_clear;
  logic [63:0] redirect_pc, cause_o;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t expq[$];

  localparam logic [2:0] A_STATUS = 3'd0, A_EPC = 3'd1, A_EVEC = 3'd2,
    A_COUNT = 3'd3, A_CMP = 3'd4, A_CAUSE = 3'd5, A_IPI = 3'd6, A_MBOX = 3'd7;

  always #5 clk = ~clk;

  trap_status_ctrl i_trap_status_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_set(irq_set),
    .irq_clr(irq_clr), .retire(retire), .cur_pc(cur_pc), .trap_req(trap_req),
    .trap_pc(trap_pc), .trap_cause(trap_cause), .trap_taken(trap_taken),
    .redirect_pc(redirect_pc), .cause_o(cause_o), .resv_clear(resv_clear)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic csr_wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_chk(input string req, input logic [2:0] a, input logic [63:0] exp);
    @(negedge clk);
    csr_addr = a;
    #1;
    chk(req, csr_rdata, exp);
  endtask

  task automatic pulse_set(input logic [2:0] s);
    @(negedge clk); irq_set = s;
    @(negedge clk); irq_set = '0;
  endtask

  task automatic pulse_clr(input logic [2:0] s);
    @(negedge clk); irq_clr = s;
    @(negedge clk); irq_clr = '0;
  endtask

  task automatic pulse_retire();
    @(negedge clk); retire = 1'b1;
    @(negedge clk); retire = 1'b0;
  endtask

  task automatic expect_trap(input logic [63:0] pc, input logic [63:0] cause);
    exp_t e;
    e.pc = pc; e.cause = cause;
    expq.push_back(e);
  endtask

  // monitor: one expected entry per strobe
  always @(negedge clk) begin
    if (rst_n === 1'b1 && trap_taken === 1'b1) begin
      if (expq.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R1: actual unexpected trap cause 0x%0h expected no trap", cause_o);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk("R5 redirect", redirect_pc, e.pc);
        chk("R3 cause", cause_o, e.cause);
        chk("R5 resv_clear", {63'b0, resv_clear}, 64'd1);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
    irq_set = '0; irq_clr = '0; retire = 1'b0; cur_pc = 64'h1234;
    trap_req = 1'b0; trap_pc = '0; trap_cause = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R9 reset state
    chk("R9 redirect", redirect_pc, 64'h2000);
    chk("R9 strobe", {62'b0, trap_taken, resv_clear}, 64'd0);
    chk("R9 cause", cause_o, 64'd0);
    csr_chk("R9 status", A_STATUS, 64'h4);
    csr_chk("R9 count", A_COUNT, 64'h0);

    // R6 pending and reserved bits not writable
    csr_wr(A_EVEC, 64'h8000);
    csr_wr(A_STATUS, 64'h40FF_20C5);
    csr_chk("R6 status write", A_STATUS, 64'h2005);

    // R8/R5 IPI via clear-IPI write, narrow cause
    expect_trap(64'h8000, 64'h8000_0005);
    csr_wr(A_IPI, 64'h1);
    idle(3);
    csr_chk("R4 status after entry", A_STATUS, 64'h20_200E);
    csr_chk("R5 epc", A_EPC, 64'h1234);
    csr_wr(A_IPI, 64'h0);
    csr_chk("R8 ipi cleared", A_STATUS, 64'h200E);
    csr_chk("R13 clr-ipi reads zero", A_IPI, 64'h0);

    // R1 masked by global enable; R2 lowest index; R3 wide cause
    pulse_set(3'b110);
    idle(2);
    csr_chk("R1 gated pending", A_STATUS, 64'hC0_200E);
    expect_trap(64'h8000, 64'h8000_0000_0000_0006);
    csr_wr(A_STATUS, 64'hE025);
    idle(3);
    csr_chk("R2 R4 status", A_STATUS, 64'hC0_E02E);
    pulse_clr(3'b110);
    csr_chk("R2 cleared", A_STATUS, 64'hE02E);

    // R11 exception beats interrupt in the same cycle
    csr_wr(A_STATUS, 64'hE025);
    expect_trap(64'h8000, 64'h2);
    @(negedge clk); irq_set = 3'b010;
    @(negedge clk); irq_set = '0; trap_req = 1'b1; trap_pc = 64'h5550; trap_cause = 64'h2;
    @(negedge clk); trap_req = 1'b0;
    idle(2);
    csr_chk("R11 epc", A_EPC, 64'h5550);
    csr_chk("R11 cause", A_CAUSE, 64'h2);
    csr_chk("R11 irq stays pending", A_STATUS, 64'h40_E02E);
    pulse_clr(3'b010);

    // R7/R10 timer crossing and compare clear
    csr_wr(A_CMP, 64'd5);
    csr_wr(A_COUNT, 64'd3);
    csr_chk("R10 count write", A_COUNT, 64'd3);
    pulse_retire();
    csr_chk("R10 count step", A_COUNT, 64'd4);
    csr_chk("R7 below compare", A_STATUS, 64'hE02E);
    pulse_retire();
    csr_chk("R7 crossing", A_STATUS, 64'h80_E02E);
    pulse_retire();
    csr_chk("R7 past compare", A_STATUS, 64'h80_E02E);
    csr_wr(A_CMP, 64'd10);
    csr_chk("R7 compare write clears", A_STATUS, 64'hE02E);
    csr_chk("R7 compare readback", A_CMP, 64'd10);

    // R12 hardware set beats CSR clear
    @(negedge clk); csr_we = 1'b1; csr_addr = A_IPI; csr_wdata = 64'h0; irq_set = 3'b001;
    @(negedge clk); csr_we = 1'b0; irq_set = '0;
    csr_chk("R12 set wins", A_STATUS, 64'h20_E02E);
    csr_wr(A_IPI, 64'h0);

    // R8 mailbox
    csr_wr(A_MBOX, 64'h77);
    csr_chk("R8 mailbox sets host", A_STATUS, 64'h40_E02E);
    csr_chk("R8 mailbox value", A_MBOX, 64'h77);
    csr_wr(A_MBOX, 64'h0);
    csr_chk("R8 mailbox zero clears", A_STATUS, 64'hE02E);

    // R10 wrap
    csr_wr(A_COUNT, 64'hFFFF_FFFF);
    pulse_retire();
    csr_chk("R10 wrap", A_COUNT, 64'h0);
    csr_chk("R7 no cross on wrap", A_STATUS, 64'hE02E);

    // R1 mask bit blocks even with global enable
    csr_wr(A_STATUS, 64'h0005);
    pulse_set(3'b001);
    idle(2);
    csr_chk("R1 masked", A_STATUS, 64'h20_0005);

    idle(2);
    chk("R5 all expected traps seen", 64'(expq.size()), 64'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule